// File: doc/BRIEF.md
# Egress Queue Shaper with Leaky Buckets

This block decides which priority queue of a single output port may send its next frame, and how long the link must then stay quiet. Each queue owns a leaky bucket. When a frame finishes, its length in bytes is charged to the bucket of the queue that sent it. The bucket drains by that queue's rate every clock cycle. The block turns the charge into an interframe-gap extension, so output leaves as evenly spaced frames and not as bursts.

A single 7-bit rate code sets the drain rate of the highest-priority active queue. Each lower queue drains at that rate shifted right by a per-queue programmable amount. With shifts of 1, 2 and 3 on the lower queues, the four rates stand in an 8:4:2:1 ratio. A mode input enables one, two or four queues. The MAC side of the block is a grant pulse, carrying a queue number, and a done pulse that closes the frame.

Top module: `egress_shaper`

## Requirements
- R1: After reset all buckets are empty, no frame is in progress and gap_ext is 0. The first ready queue is granted in the first idle cycle.
- R2: q_mode selects the active queues: 0 gives queue 0 only, 1 gives queues 0..1, and 2 or 3 give queues 0..3. A queue outside the active set is never granted.
- R3: When the block is idle and no gap remains, tx_grant is raised in the same cycle for the highest-numbered active queue that is ready and whose bucket is empty. tx_queue carries that queue's number. If no queue qualifies, no grant is made.
- R4: Only one frame is in flight at a time. After a grant, no further grant is made until tx_done. A tx_done pulse with no frame in flight has no effect.
- R5: The length charged at tx_done is the q_len value of the granted queue, captured in the grant cycle. Later changes to q_len do not alter it.
- R6: On the edge that accepts tx_done, the bucket of the granted queue becomes max(level − drain, 0) + length. On the same edge, gap_ext loads ceil(bucket / drain). gap_ext then falls by one each cycle, and no grant is made while it is nonzero.
- R7: The highest active queue drains rate_code bytes per cycle.
- R8: Every lower active queue k drains rate_code >> ratio_shift[2k+1:2k] bytes per cycle. A result of 0 becomes 1.
- R9: A rate_code of 0 disables shaping: buckets stay empty and gap_ext loads 0.
- R10: Every bucket drains each cycle and saturates at zero. Idle time builds no credit, and a queue whose bucket is nonzero is not eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_ready | input | NQ | Per-queue head-frame-present flags |
| q_len | input | NQ*LEN_W | Head frame length in bytes, queue k at [k*LEN_W +: LEN_W] |
| rate_code | input | RATE_W | Drain rate of the top active queue, bytes per cycle; 0 = unshaped |
| q_mode | input | 2 | Active queue count selector |
| ratio_shift | input | NQ*SH_W | Right-shift applied to the rate for each lower queue |
| tx_done | input | 1 | Pulse from the MAC: the granted frame has finished |
| tx_grant | output | 1 | One-cycle pulse: start the frame of tx_queue |
| tx_queue | output | QW | Queue number being granted |
| gap_ext | output | BKT_W | Remaining gap-extension cycles |

## Verification
The charge of a finished frame and the per-cycle leak of the same bucket happen on the same edge. The charged value must be leak-then-add, and the gap load must override the countdown. Both directed frames and random traffic finish frames at all moments of a bucket's drain. Random changes to rate, mode and ratio during gaps leave buckets with residue when tx_done arrives. A bench model predicts the bucket after each edge and compares the resulting gap_ext. Gap expiry and a new grant also meet in one cycle, and the bench checks that the grant comes exactly in the first cycle in which gap_ext reads zero.

// File: rtl/egress_shaper_pkg.sv
package egress_shaper_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} tx_state_e;

  // number of enabled queues for a mode code, clamped to the queue count
  function automatic int unsigned active_queues(input logic [1:0] mode,
                                                input int unsigned nq_max);
    int unsigned n;
    n = 32'd1 << mode;
    if (n > nq_max) n = nq_max;
    return n;
  endfunction

  // per-queue drain: the top queue takes the rate itself, the others a shifted copy
  function automatic logic [31:0] queue_drain(input logic [31:0] rate,
                                              input logic [31:0] shift,
                                              input logic        is_top);
    logic [31:0] d;
    d = is_top ? rate : (rate >> shift);
    if (d == 32'd0) d = 32'd1;
    return d;
  endfunction

  // ceiling of num / den by restoring long division, den must be nonzero
  function automatic logic [31:0] ceil_div(input logic [31:0] num,
                                           input logic [31:0] den);
    logic [31:0] q;
    logic [32:0] r;
    q = '0;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      r = {r[31:0], num[i]};
      if (r >= {1'b0, den}) begin
        r = r - {1'b0, den};
        q[i] = 1'b1;
      end
    end
    if (r != 33'd0) q = q + 32'd1;
    return q;
  endfunction

endpackage

// File: rtl/shaper_bucket.sv
module shaper_bucket #(
  parameter int BKT_W  = 16,
  parameter int LEN_W  = 14,
  parameter int RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlimited,
  input  logic [RATE_W-1:0] drain,
  input  logic              charge,
  input  logic [LEN_W-1:0]  charge_len,
  output logic [BKT_W-1:0]  level,
  output logic [BKT_W-1:0]  charged_level,
  output logic              empty
);
  localparam logic [BKT_W:0] SAT_MAX = {1'b0, {BKT_W{1'b1}}};

  logic [BKT_W-1:0] leak;
  logic [BKT_W:0]   sum;
  logic [BKT_W-1:0] level_nx;

  always_comb begin
    leak = (level > BKT_W'(drain)) ? (level - BKT_W'(drain)) : '0;
    sum  = {1'b0, leak} + (BKT_W+1)'(charge_len);
    charged_level = (sum > SAT_MAX) ? SAT_MAX[BKT_W-1:0] : sum[BKT_W-1:0];
    if (unlimited)   level_nx = '0;
    else if (charge) level_nx = charged_level;
    else             level_nx = leak;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= level_nx;
  end

  assign empty = (level == '0);

  // R10: an uncharged, nonempty bucket strictly shrinks
  p_bucket_leaks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge && level != '0) |=> (level < $past(level)));

  // R9: unshaped operation keeps the bucket at zero
  p_unlimited_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unlimited |=> (level == '0));

  // R6: a charge leaves at least the frame length in the bucket
  p_charge_holds_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (charge && !unlimited) |=> (level >= BKT_W'($past(charge_len))));

endmodule

// File: rtl/shaper_pick.sv
module shaper_pick #(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input  logic [NQ-1:0] cand,
  input  logic          allow,
  output logic          grant,
  output logic [QW-1:0] sel
);
  always_comb begin
    grant = 1'b0;
    sel   = '0;
    for (int k = 0; k < NQ; k++) begin
      if (cand[k]) begin
        sel   = QW'(k);
        grant = allow;
      end
    end
  end

  // R3: a grant always names a candidate, and one is granted whenever allowed
  always_comb begin
    if (grant) a_pick_is_cand_r3: assert (cand[sel]);
    if (allow && cand != '0) a_pick_taken_r3: assert (grant);
  end

endmodule

// File: rtl/shaper_gap.sv
module shaper_gap #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic [GAP_W-1:0] count,
  output logic             idle
);
  always_ff @(posedge clk) begin
    if (!rst_n)             count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - GAP_W'(1);
  end

  assign idle = (count == '0);

  // R6: the gap counts down by exactly one per cycle unless reloaded
  p_gap_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == $past(count) - GAP_W'(1)));

  // R6: a load takes effect on the next edge
  p_gap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

endmodule

// File: rtl/egress_shaper.sv
module egress_shaper
  import egress_shaper_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int LEN_W  = 14,
  parameter int RATE_W = 7,
  parameter int SH_W   = 2,
  parameter int BKT_W  = 16,
  parameter int QW     = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       q_ready,
  input  logic [NQ*LEN_W-1:0] q_len,
  input  logic [RATE_W-1:0]   rate_code,
  input  logic [1:0]          q_mode,
  input  logic [NQ*SH_W-1:0]  ratio_shift,
  input  logic                tx_done,
  output logic                tx_grant,
  output logic [QW-1:0]       tx_queue,
  output logic [BKT_W-1:0]    gap_ext
);
  localparam int GAP_W = BKT_W;

  tx_state_e          state;
  logic [QW-1:0]      cur_q;
  logic [LEN_W-1:0]   cur_len;
  int unsigned        nq_act;
  logic               unlimited;
  logic               frame_done;
  logic               gap_idle;
  logic               allow;
  logic [GAP_W-1:0]   gap_load_val;

  logic [NQ-1:0]      active;
  logic [NQ-1:0]      empty;
  logic [NQ-1:0]      charge;
  logic [NQ-1:0]      cand;
  logic [RATE_W-1:0]  drain_a   [NQ];
  logic [BKT_W-1:0]   level_a   [NQ];
  logic [BKT_W-1:0]   charged_a [NQ];
  logic [LEN_W-1:0]   len_a     [NQ];

  always_comb begin
    nq_act    = active_queues(q_mode, NQ);
    unlimited = (rate_code == '0);
  end

  assign frame_done = (state == ST_BUSY) && tx_done;
  assign allow      = (state == ST_IDLE) && gap_idle;

  for (genvar k = 0; k < NQ; k++) begin : g_q
    assign len_a[k]  = q_len[k*LEN_W +: LEN_W];
    assign active[k] = (k < nq_act);
    assign drain_a[k] = RATE_W'(queue_drain(32'(rate_code),
                                            32'(ratio_shift[k*SH_W +: SH_W]),
                                            (k == nq_act - 1)));
    assign charge[k] = frame_done && (cur_q == QW'(k));
    assign cand[k]   = active[k] && q_ready[k] && empty[k];

    shaper_bucket #(.BKT_W(BKT_W), .LEN_W(LEN_W), .RATE_W(RATE_W)) u_bucket (
      .clk           (clk),
      .rst_n         (rst_n),
      .unlimited     (unlimited),
      .drain         (drain_a[k]),
      .charge        (charge[k]),
      .charge_len    (cur_len),
      .level         (level_a[k]),
      .charged_level (charged_a[k]),
      .empty         (empty[k])
    );
  end

  shaper_pick #(.NQ(NQ), .QW(QW)) u_pick (
    .cand  (cand),
    .allow (allow),
    .grant (tx_grant),
    .sel   (tx_queue)
  );

  always_comb begin
    if (unlimited) gap_load_val = '0;
    else gap_load_val = GAP_W'(ceil_div(32'(charged_a[cur_q]), 32'(drain_a[cur_q])));
  end

  shaper_gap #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_done),
    .load_val (gap_load_val),
    .count    (gap_ext),
    .idle     (gap_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_q   <= '0;
      cur_len <= '0;
    end else if (tx_grant) begin
      state   <= ST_BUSY;
      cur_q   <= tx_queue;
      cur_len <= len_a[tx_queue];
    end else if (frame_done) begin
      state   <= ST_IDLE;
    end
  end

  // R4: a grant is followed by a busy cycle, never a second grant
  p_single_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  // R6: nothing is granted while a gap extension remains
  p_no_grant_in_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_ext != '0) |-> !tx_grant);

  // R2: only an enabled queue can be granted
  p_active_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (int'(tx_queue) < int'(nq_act)));

  // R10: the granted queue's bucket is empty
  p_grant_eligible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (level_a[tx_queue] == '0 && q_ready[tx_queue]));

  // R9: an unshaped frame leaves no gap
  p_unlimited_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rate_code == '0) |=> (gap_ext == '0));

  // R4: a done pulse with no frame in flight does not start a gap
  p_stray_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && state == ST_IDLE && gap_ext == '0) |=> (gap_ext == '0));

endmodule

// File: tb/tb_egress_shaper.sv
module tb_egress_shaper;
  localparam int NQ = 4, LEN_W = 14, RATE_W = 7, SH_W = 2, BKT_W = 16, QW = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NQ-1:0]       q_ready = '0;
  logic [NQ*LEN_W-1:0] q_len = '0;
  logic [RATE_W-1:0]   rate_code = 7'd10;
  logic [1:0]          q_mode = 2'd2;
  logic [NQ*SH_W-1:0]  ratio_shift = {2'd0, 2'd1, 2'd2, 2'd3};
  logic                tx_done = 1'b0;
  logic                tx_grant;
  logic [QW-1:0]       tx_queue;
  logic [BKT_W-1:0]    gap_ext;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;

  // reference state
  int  m_b[NQ];
  bit  m_busy;
  int  m_q, m_len, m_gap;

  egress_shaper #(.NQ(NQ), .LEN_W(LEN_W), .RATE_W(RATE_W), .SH_W(SH_W), .BKT_W(BKT_W)) dut (
    .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .q_len(q_len), .rate_code(rate_code),
    .q_mode(q_mode), .ratio_shift(ratio_shift), .tx_done(tx_done),
    .tx_grant(tx_grant), .tx_queue(tx_queue), .gap_ext(gap_ext));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int n_active(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  // R7 / R8: rate for queue k from the requirements
  function automatic int q_rate(input int k, input int nq, input int rate, input int sh);
    int d;
    d = (k == nq - 1) ? rate : (rate >> sh);
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // lockstep reference, compares then advances to the state after the next edge
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      foreach (m_b[k]) m_b[k] = 0;
      m_busy = 0; m_q = 0; m_len = 0; m_gap = 0;
    end else if (chk_en) begin
      int nq, pick, old_b;
      int d[NQ];
      bit g, unl;
      nq = n_active(q_mode);
      unl = (rate_code == 0);
      for (int k = 0; k < NQ; k++)
        d[k] = q_rate(k, nq, int'(rate_code), int'(ratio_shift[k*SH_W +: SH_W]));
      g = 0; pick = 0;
      if (!m_busy && m_gap == 0)
        for (int k = nq - 1; k >= 0; k--)
          if (!g && q_ready[k] && m_b[k] == 0) begin g = 1; pick = k; end
      check(tx_grant == g, "R3 grant", int'(tx_grant), int'(g));
      if (g && tx_grant) check(int'(tx_queue) == pick, "R3 queue", int'(tx_queue), pick);
      check(int'(gap_ext) == m_gap, "R6 gap", int'(gap_ext), m_gap);
      old_b = m_b[m_q];
      for (int k = 0; k < NQ; k++) m_b[k] = unl ? 0 : ((m_b[k] > d[k]) ? m_b[k] - d[k] : 0);
      if (m_busy && tx_done) begin
        if (unl) m_gap = 0;
        else begin
          old_b = (old_b > d[m_q]) ? old_b - d[m_q] : 0;
          m_b[m_q] = old_b + m_len;
          if (m_b[m_q] > 65535) m_b[m_q] = 65535;
          m_gap = cdiv(m_b[m_q], d[m_q]);
        end
        m_busy = 0;
      end else if (m_gap != 0) m_gap--;
      if (g) begin
        m_busy = 1; m_q = pick; m_len = int'(q_len[pick*LEN_W +: LEN_W]);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_len(input int len);
    for (int k = 0; k < NQ; k++) q_len[k*LEN_W +: LEN_W] = LEN_W'(len);
  endtask

  // wait for a grant, finish the frame and check the resulting gap
  task automatic send(input int exp_q, input int len, input int exp_gap, input string req);
    int waited;
    set_len(len);
    waited = 0;
    do begin
      @(negedge clk); #1; waited++;
    end while (!tx_grant && waited < 5000);
    check(tx_grant == 1'b1, {req, " grant seen"}, int'(tx_grant), 1);
    check(int'(tx_queue) == exp_q, {req, " queue"}, int'(tx_queue), exp_q);
    tick();
    q_ready = '0;
    set_len(999);  // R5: late length change must not be charged
    tick(); tick();
    tx_done = 1'b1;
    tick();
    tx_done = 1'b0;
    @(negedge clk); #1;
    check(int'(gap_ext) == exp_gap, {req, " R5 gap after done"}, int'(gap_ext), exp_gap);
    if (exp_gap > 1) begin
      @(negedge clk); #1;
      check(int'(gap_ext) == exp_gap - 1, "R6 countdown", int'(gap_ext), exp_gap - 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    chk_en = 1'b1;
    @(negedge clk); #1;
    check(tx_grant == 1'b0, "R1 no grant after reset", int'(tx_grant), 0);
    check(gap_ext == '0, "R1 gap after reset", int'(gap_ext), 0);
    tick();
    q_ready = 4'b1000;
    send(3, 100, 10, "R7 top rate");        // drain 10
    q_ready = 4'b0101;
    send(2, 100, 20, "R3 R8 half rate");    // drain 10>>1 = 5
    q_ready = 4'b0001;
    send(0, 7, 7, "R8 eighth rate");        // drain 10>>3 = 1
    rate_code = 7'd3;
    q_ready = 4'b0010;
    send(1, 5, 5, "R8 floor to one");       // 3>>2 = 0 -> 1
    rate_code = 7'd0;
    q_ready = 4'b1000;
    send(3, 500, 0, "R9 unshaped");
    rate_code = 7'd10;
    repeat (50) tick();
    q_ready = 4'b1000;
    send(3, 30, 3, "R10 no idle credit");
    repeat (5) tick();
    tx_done = 1'b1;                         // stray done
    tick();
    tx_done = 1'b0;
    @(negedge clk); #1;
    check(gap_ext == '0, "R4 stray done ignored", int'(gap_ext), 0);
    tick();
    q_ready = 4'b1000;
    @(negedge clk); #1;
    check(tx_grant == 1'b1, "R4 grant right after stray done", int'(tx_grant), 1);
    tick();
    q_ready = 4'b0000;
    tick();
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    repeat (10) tick();
    q_mode = 2'd0;
    q_ready = 4'b1110;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      check(tx_grant == 1'b0, "R2 inactive queues", int'(tx_grant), 0);
    end
    tick();
    q_ready = 4'b0001;
    send(0, 40, 4, "R2 R7 single queue top");
    q_mode = 2'd1;
    q_ready = 4'b1111;
    send(1, 20, 2, "R2 two queues");
    // random traffic with occasional reconfiguration
    for (int c = 0; c < 6000; c++) begin
      q_ready = NQ'($urandom);
      for (int k = 0; k < NQ; k++) q_len[k*LEN_W +: LEN_W] = LEN_W'(1 + $urandom % 300);
      if ($urandom % 64 == 0) q_mode = 2'($urandom);
      if ($urandom % 64 == 0) rate_code = ($urandom % 8 == 0) ? 7'd0 : 7'($urandom);
      if ($urandom % 64 == 0) ratio_shift = 8'($urandom);
      tx_done = ($urandom % 4 == 0) && (m_busy || ($urandom % 4 == 0));
      tick();
    end
    tx_done = 1'b0;
    tick();
    chk_en = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule